// File: doc/BRIEF.md
# Latched Second-Level Interrupt Controller

This block gathers a vector of interrupt sources into one request line for a parent controller. Every source owns two bits: a pending bit, which latches a high request and holds it until software acknowledges it, and a disable bit. The parent sees the OR of all bits that are pending and not disabled.

Software works through a word-wide register port with byte-offset addressing. Neither the pending vector nor the disable vector is ever written directly. Each has one address that sets bits and another that clears them. A one in the written word acts on that bit position. A zero leaves that position alone. Software can also raise a pending bit by itself, which lets it test a handler without a hardware event.

The address decoder maps each offset to one named selection. `SEL_STAT` reads the pending vector. `SEL_STAT_SET` raises pending bits. `SEL_STAT_CLR` acknowledges pending bits. `SEL_MASK` reads the disable vector. `SEL_MASK_SET` disables sources. `SEL_MASK_CLR` enables sources. `SEL_NONE` covers every other offset. There is no sequencing between accesses: every write takes effect on the next clock edge, and every read returns its data one cycle later.

Top module: `latched_irq_ctrl`

## Requirements
- R1: After reset every disable bit is one, every pending bit is zero and `irq_out` is low.
- R2: A source input that is high at a clock edge sets its pending bit. The bit stays set after the input falls, and also while the input stays high, until it is acknowledged with the input low.
- R3: A write to offset 0x04 sets the pending bit for each one bit in the written word.
- R4: A write to offset 0x08 clears the pending bit for each one bit in the written word. Pending bits where the word has a zero keep their value.
- R5: A write to offset 0x10 sets the disable bit for each one bit in the word. A write to offset 0x14 clears them. A read of offset 0x0C returns the disable vector, where a one means the source is disabled.
- R6: `irq_out` is high exactly when some bit is both pending and not disabled. It reflects the state left by the most recent clock edge.
- R7: If a source input is high in the same cycle as an acknowledge of that bit, the bit stays pending.
- R8: Writing all ones to 0x10 and then all ones to 0x08 leaves every source disabled, nothing pending and `irq_out` low.
- R9: Reads of offsets 0x04, 0x08, 0x10 and 0x14 and of any unmapped offset return zero. Writes to unmapped offsets change nothing.
- R10: `rd_data` is registered. It carries the value selected in the cycle `rd_en` was high, and it is zero in the cycle after `rd_en` was low.
- R11: A disabled source still latches its pending bit. Disabling a source hides the bit from `irq_out` but does not block it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (5) | Byte offset of the access |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_data | input | NSRC (32) | Write data, one bit per source |
| rd_en | input | 1 | Read strobe for one cycle |
| rd_data | output | NSRC (32) | Registered read data |
| src_req | input | NSRC (32) | Level requests from the sources |
| irq_out | output | 1 | Combined request to the parent |

## Verification
A write or a high source input changes the pending and disable bits at the next rising edge. `irq_out` follows from those flops without any further delay, so the bench drives stimulus on a falling edge and checks `irq_out` on the following falling edge. Read data is due one edge after the `rd_en` cycle. The read task pushes the expected word into a queue when it issues the read. A monitor pops and compares that word on the falling edge after the capturing edge. Expected words come from a bench model that applies set, clear and source effects as the requirements state. Reads are never issued in the same cycle as a write, so the model state at issue is the state the read captures.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    // Byte offsets. Software depends on these values, so they are fixed.
    localparam logic [31:0] OFF_STAT     = 32'h00;
    localparam logic [31:0] OFF_STAT_SET = 32'h04;
    localparam logic [31:0] OFF_STAT_CLR = 32'h08;
    localparam logic [31:0] OFF_MASK     = 32'h0C;
    localparam logic [31:0] OFF_MASK_SET = 32'h10;
    localparam logic [31:0] OFF_MASK_CLR = 32'h14;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_STAT_SET,
        SEL_STAT_CLR,
        SEL_MASK,
        SEL_MASK_SET,
        SEL_MASK_CLR
    } reg_sel_e;

    function automatic reg_sel_e sel_of(input logic [31:0] off);
        reg_sel_e s;
        case (off)
            OFF_STAT:     s = SEL_STAT;
            OFF_STAT_SET: s = SEL_STAT_SET;
            OFF_STAT_CLR: s = SEL_STAT_CLR;
            OFF_MASK:     s = SEL_MASK;
            OFF_MASK_SET: s = SEL_MASK_SET;
            OFF_MASK_CLR: s = SEL_MASK_CLR;
            default:      s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NSRC-1:0]   wr_data,
    output reg_sel_e          sel,
    output logic [NSRC-1:0]   stat_set,
    output logic [NSRC-1:0]   stat_clr,
    output logic [NSRC-1:0]   mask_set,
    output logic [NSRC-1:0]   mask_clr
);

    localparam int PAD_W = 32 - ADDR_W;

    logic [31:0] off_w;
    assign off_w = {{PAD_W{1'b0}}, addr};
    assign sel   = sel_of(off_w);

    // One-hot write strobes: at most one of the four vectors is nonzero.
    always_comb begin
        stat_set = '0;
        stat_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_STAT_SET: stat_set = wr_data;
                SEL_STAT_CLR: stat_clr = wr_data;
                SEL_MASK_SET: mask_set = wr_data;
                SEL_MASK_CLR: mask_clr = wr_data;
                SEL_NONE, SEL_STAT, SEL_MASK: ;
            endcase
        end
    end

endmodule

// File: rtl/irqagg_cell.sv
module irqagg_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic st_set,
    input  logic st_clr,
    input  logic mk_set,
    input  logic mk_clr,
    output logic stat,
    output logic mask,
    output logic pend
);

    logic stat_q;
    logic mask_q;

    // The hardware request is ORed in after the clear, so it wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            stat_q <= (stat_q & ~st_clr) | st_set | src;
            mask_q <= (mask_q | mk_set) & ~mk_clr;
        end
    end

    assign stat = stat_q;
    assign mask = mask_q;
    assign pend = stat_q & ~mask_q;

endmodule

// File: rtl/irqagg_readback.sv
module irqagg_readback
    import irqagg_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  reg_sel_e        sel,
    input  logic [NSRC-1:0] stat_vec,
    input  logic [NSRC-1:0] mask_vec,
    output logic [NSRC-1:0] rd_data
);

    logic [NSRC-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_STAT: rd_next = stat_vec;
                SEL_MASK: rd_next = mask_vec;
                SEL_NONE, SEL_STAT_SET, SEL_STAT_CLR,
                SEL_MASK_SET, SEL_MASK_CLR: rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_next;
    end

endmodule

// File: rtl/latched_irq_ctrl.sv
module latched_irq_ctrl
    import irqagg_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [NSRC-1:0]   wr_data,
    input  logic              rd_en,
    output logic [NSRC-1:0]   rd_data,
    input  logic [NSRC-1:0]   src_req,
    output logic              irq_out
);

    reg_sel_e        sel;
    logic [NSRC-1:0] stat_set;
    logic [NSRC-1:0] stat_clr;
    logic [NSRC-1:0] mask_set;
    logic [NSRC-1:0] mask_clr;
    logic [NSRC-1:0] stat_vec;
    logic [NSRC-1:0] mask_vec;
    logic [NSRC-1:0] pend_vec;

    irqagg_decode #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_decode (
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .sel      (sel),
        .stat_set (stat_set),
        .stat_clr (stat_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        irqagg_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (src_req[i]),
            .st_set (stat_set[i]),
            .st_clr (stat_clr[i]),
            .mk_set (mask_set[i]),
            .mk_clr (mask_clr[i]),
            .stat   (stat_vec[i]),
            .mask   (mask_vec[i]),
            .pend   (pend_vec[i])
        );
    end

    irqagg_readback #(.NSRC(NSRC)) u_readback (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .sel      (sel),
        .stat_vec (stat_vec),
        .mask_vec (mask_vec),
        .rd_data  (rd_data)
    );

    assign irq_out = |pend_vec;

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
    import irqagg_pkg::*;
#(
    parameter int NSRC   = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [NSRC-1:0]   wr_data,
    input logic              rd_en,
    input logic [NSRC-1:0]   rd_data,
    input logic [NSRC-1:0]   src_req,
    input logic              irq_out,
    input logic [NSRC-1:0]   stat_vec,
    input logic [NSRC-1:0]   mask_vec
);

    localparam int PAD_W = 32 - ADDR_W;

    logic [31:0] off;
    assign off = {{PAD_W{1'b0}}, addr};

    // R2: a high source is latched at the next edge
    a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_vec & $past(src_req)) == $past(src_req)));

    // R4 and R7: an acknowledged bit ends up clear unless its source was high
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_STAT_CLR) |=>
            ((stat_vec & $past(wr_data) & ~$past(src_req)) == '0));

    // R5: disable bits follow the set and clear addresses
    a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_MASK_SET) |=>
            ((mask_vec & $past(wr_data)) == $past(wr_data)));

    a_r5_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_MASK_CLR) |=> ((mask_vec & $past(wr_data)) == '0));

    // R9: disable bits change only through the two mask addresses
    a_r9_mask_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (off == OFF_MASK_SET || off == OFF_MASK_CLR)) |=> $stable(mask_vec));

    // R6: the combined line matches the pending and enabled bits
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == ((stat_vec & ~mask_vec) != '0));

    // R9: only the two read-back addresses return data
    a_r9_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && off != OFF_STAT && off != OFF_MASK) |=> (rd_data == '0));

    // R10: no read strobe means zero data the next cycle
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

endmodule

bind latched_irq_ctrl irqagg_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .src_req  (src_req),
    .irq_out  (irq_out),
    .stat_vec (stat_vec),
    .mask_vec (mask_vec)
);

// File: tb/latched_irq_ctrl_bench.sv
module latched_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 32;
    localparam int ADDR_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic [NSRC-1:0]   wr_data = '0;
    logic              rd_en = 1'b0;
    logic [NSRC-1:0]   rd_data;
    logic [NSRC-1:0]   src_req = '0;
    logic              irq_out;

    int checks   = 0;
    int failures = 0;

    logic [NSRC-1:0] m_stat;
    logic [NSRC-1:0] m_mask;

    logic [NSRC-1:0] exp_q[$];
    string           tag_q[$];
    logic            rd_pend = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    latched_irq_ctrl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_latched_irq_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .src_req (src_req),
        .irq_out (irq_out)
    );

    task automatic check(input string tag, input logic [NSRC-1:0] act,
                         input logic [NSRC-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares read data one edge after the read cycle.
    always @(posedge clk) rd_pend <= rd_en;
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected read", rd_data, '0);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Write, with an optional source pattern high in the same cycle.
    task automatic wr_src(input logic [7:0] a, input logic [NSRC-1:0] d,
                          input logic [NSRC-1:0] s);
        @(negedge clk);
        addr    = a[ADDR_W-1:0];
        wr_data = d;
        wr_en   = 1'b1;
        src_req = s;
        @(negedge clk);
        wr_en   = 1'b0;
        src_req = '0;
        case (a)
            8'h04: m_stat = m_stat | d;
            8'h08: m_stat = m_stat & ~d;
            8'h10: m_mask = m_mask | d;
            8'h14: m_mask = m_mask & ~d;
            default: ;
        endcase
        m_stat = m_stat | s;
    endtask

    task automatic wr(input logic [7:0] a, input logic [NSRC-1:0] d);
        wr_src(a, d, '0);
    endtask

    task automatic pulse_src(input logic [NSRC-1:0] s, input int cycles);
        @(negedge clk);
        src_req = s;
        for (int k = 0; k < cycles; k++) @(negedge clk);
        src_req = '0;
        m_stat = m_stat | s;
    endtask

    // Driver: pushes the expected word and issues the read.
    task automatic rd(input logic [7:0] a, input string tag);
        logic [NSRC-1:0] e;
        e = (a == 8'h00) ? m_stat : (a == 8'h0C) ? m_mask : '0;
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr  = a[ADDR_W-1:0];
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input string tag);
        logic [NSRC-1:0] e;
        e = {{(NSRC-1){1'b0}}, ((m_stat & ~m_mask) != '0)};
        check(tag, {{(NSRC-1){1'b0}}, irq_out}, e);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_stat = '0;
        m_mask = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, R10: idle read data
        chk_irq("R1 irq after reset");
        check("R10 rd_data idle", rd_data, '0);
        rd(8'h0C, "R1 mask after reset");
        rd(8'h00, "R1 status after reset");

        // R2 and R11: masked sources still latch
        pulse_src(32'h0000_0005, 1);
        rd(8'h00, "R11 masked source latched");
        chk_irq("R11 masked bit hidden");

        // R5 and R6: enable bit 0
        wr(8'h14, 32'h0000_0001);
        rd(8'h0C, "R5 mask read after clear");
        chk_irq("R6 irq high when enabled");

        // R4: zeros keep their value
        wr(8'h08, 32'h0000_0004);
        rd(8'h00, "R4 partial ack");
        chk_irq("R6 irq still high");
        wr(8'h08, 32'h0000_0001);
        rd(8'h00, "R4 full ack");
        chk_irq("R6 irq low after ack");

        // R3: software raise
        wr(8'h04, 32'h8000_0000);
        rd(8'h00, "R3 software set");
        chk_irq("R3 disabled set hidden");
        wr(8'h14, 32'h8000_0000);
        chk_irq("R3 raised bit drives irq");
        rd(8'h0C, "R5 two enabled");

        // R5: disabling a pending source drops irq
        wr(8'h10, 32'h8000_0000);
        chk_irq("R5 disable drops irq");
        wr(8'h14, 32'h8000_0000);

        // R7: hardware wins a collision with an acknowledge
        wr_src(8'h08, 32'h8000_0010, 32'h0000_0010);
        rd(8'h00, "R7 collision keeps bit");

        // R2: held source keeps status through an ack
        @(negedge clk);
        src_req = 32'h0000_0100;
        @(negedge clk);
        wr_src(8'h08, 32'h0000_0100, 32'h0000_0100);
        src_req = 32'h0000_0100;
        m_stat = m_stat | 32'h0000_0100;
        rd(8'h00, "R2 held source survives ack");
        src_req = '0;
        @(negedge clk);
        wr(8'h08, 32'h0000_0100);
        rd(8'h00, "R2 ack after source drops");

        // R9: write-only and unmapped offsets read zero, unmapped writes ignored
        rd(8'h04, "R9 read status-set");
        rd(8'h08, "R9 read status-clear");
        rd(8'h10, "R9 read mask-set");
        rd(8'h14, "R9 read mask-clear");
        rd(8'h18, "R9 read unmapped 18");
        rd(8'h1C, "R9 read unmapped 1C");
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h1C, 32'h0000_0000);
        rd(8'h00, "R9 status after unmapped write");
        rd(8'h0C, "R9 mask after unmapped write");

        // R8: disable everything, then acknowledge everything
        wr(8'h04, 32'h00F0_0000);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h0C, "R8 all disabled");
        rd(8'h00, "R8 nothing pending");
        chk_irq("R8 irq low");
        @(negedge clk);
        check("R10 rd_data zero after read", rd_data, '0);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule